// File: doc/BRIEF.md
# Windowed External Watchdog Monitor

This block supervises software through a windowed watchdog. It has four byte-wide registers on a simple single-cycle bus. Writes that the block refuses get a bus error response in the same cycle. When the watchdog is enabled, a saturating counter starts from zero. Software restarts the counter by writing a two-byte key to the service register. The key counts only if its second byte lands inside a window that runs from the low compare value up to the high compare value.

The fault output is asserted and held until reset by any of these events:
- a wrong key byte;
- a second key byte that arrives too late;
- a key completed before the counter reaches the low compare value;
- the counter passing the high compare value;
- the external monitor pin sitting at its active level while monitoring of that pin is enabled.

An interrupt line follows the fault while the interrupt enable bit is set. The configuration fields can be written only once after reset. The bus clears the interrupt enable bit at any time.

Top module: `ext_watchdog_mon`

## Requirements
- R1: After reset the control register (offset 0) reads 0x00, the low compare (offset 2) reads 0x00, the high compare (offset 3) reads 0xFF, and fault_out and irq_out are 0.
- R2: Control bit 0 is enable, bit 1 selects the monitor pin's active level, and bit 2 enables the monitor pin. Bits 0 to 2 take the first control write after reset. A later control write that would change any of bits 0 to 2 gets bus_err=1 and leaves them unchanged. Bit 3 (interrupt enable) takes every written value. Bits 7:4 always read 0.
- R3: The low and high compare registers each take only their first write after reset. A second write to either one gets bus_err=1, and the stored value does not change.
- R4: The service register at offset 1 always reads 0x00, and a write to it never gets bus_err.
- R5: Writing enable=1 starts the counter at zero, and the counter then adds one per cycle, saturating at its maximum. When the counter is strictly above the high compare value, fault_out is asserted. If the enabling write takes effect at clock edge E, fault_out is 0 after edge E+hi+1 and 1 after edge E+hi+2. A high compare value of 0xFF never trips.
- R6: A valid refresh has two parts. The byte 0xB4 is written to the service register at edge F. The byte 0x2C follows at edge F+k, where 1 <= k <= KEY_WINDOW. If the counter at that edge is between the low and high compare values (inclusive), the counter restarts from zero and fault_out stays 0.
- R7: Each of the following asserts fault_out after the edge where it happens:
  - a first service byte other than 0xB4;
  - a second byte other than 0x2C;
  - no second byte by edge F+KEY_WINDOW, in which case the fault shows after edge F+KEY_WINDOW+1.
- R8: A valid key completed while the counter is below the low compare value asserts fault_out. A key completed with the counter equal to the low compare value is accepted.
- R9: With monitoring enabled, mon_in is active low when bit 1 is 0 and active high when bit 1 is 1. Its active level reaches fault_out after SYNC_STAGES+1 edges. With bit 2 clear, mon_in has no effect.
- R10: fault_out stays asserted until reset, and a later valid key does not clear it. While enable is 0, service writes and mon_in cannot assert fault_out.
- R11: irq_out is 1 exactly when fault_out is 1 and bit 3 is set. A control write with bit 3 at 0 (bits 0 to 2 unchanged) drops irq_out without an error.
- R12: If the first control write leaves enable at 0, the block stays disabled until reset. A later write with enable=1 gets bus_err=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response for a refused write, same cycle |
| mon_in | input | 1 | External monitor pin |
| fault_out | output | 1 | Sticky fault indication |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: KEY_WINDOW of 15 cycles and a two-stage synchroniser on the monitor pin. With these values, a test can sit exactly on the last accepted key gap (15) and on the first late one (16), and can count the synchroniser latency in whole edges. Because the compare registers are 8 bits wide, a test can set the window to a few tens of cycles. That brings the expiry edge, the low-compare boundary and a restart followed by a second expiry within a short run. The 0xFF setting can also be held long enough to cross counter saturation. Random windows and refresh timings are checked against edge arithmetic kept in the bench.

// File: rtl/ewm_pkg.sv
package ewm_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_SERV  = 2'd1,
    REG_CMPLO = 2'd2,
    REG_CMPHI = 2'd3
  } ewm_reg_e;

  // bit3 irq enable, bit2 pin monitor enable, bit1 pin active level, bit0 enable
  typedef struct packed {
    logic irq_en;
    logic pin_en;
    logic pin_pol;
    logic enable;
  } ewm_ctrl_t;

  localparam int CTRL_W     = $bits(ewm_ctrl_t);
  localparam int LOCKED_W   = 3;

  function automatic logic win_expired(logic [REG_W-1:0] cnt, logic [REG_W-1:0] hi);
    return cnt > hi;
  endfunction

  function automatic logic win_early(logic [REG_W-1:0] cnt, logic [REG_W-1:0] lo);
    return cnt < lo;
  endfunction

  function automatic logic pin_active(logic pin, logic pol);
    return pol ? pin : ~pin;
  endfunction

  function automatic logic [REG_W-1:0] sat_inc(logic [REG_W-1:0] v);
    return (v == {REG_W{1'b1}}) ? v : v + 1'b1;
  endfunction

endpackage

// File: rtl/ewm_regs.sv
module ewm_regs
  import ewm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              err,
  output ewm_ctrl_t         ctrl,
  output logic [REG_W-1:0]  cmp_lo,
  output logic [REG_W-1:0]  cmp_hi,
  output logic              serv_wr,
  output logic              enable_rise
);

  logic ctrl_locked, lo_locked, hi_locked;
  logic wr_ctrl, wr_lo, wr_hi;
  logic ctrl_err, lo_err, hi_err;
  logic [LOCKED_W-1:0] held_bits;

  assign wr_ctrl = sel && wr && (ewm_reg_e'(addr) == REG_CTRL);
  assign serv_wr = sel && wr && (ewm_reg_e'(addr) == REG_SERV);
  assign wr_lo   = sel && wr && (ewm_reg_e'(addr) == REG_CMPLO);
  assign wr_hi   = sel && wr && (ewm_reg_e'(addr) == REG_CMPHI);

  assign held_bits = {ctrl.pin_en, ctrl.pin_pol, ctrl.enable};

  assign ctrl_err = wr_ctrl && ctrl_locked && (wdata[LOCKED_W-1:0] != held_bits);
  assign lo_err   = wr_lo && lo_locked;
  assign hi_err   = wr_hi && hi_locked;
  assign err      = ctrl_err || lo_err || hi_err;

  assign enable_rise = wr_ctrl && !ctrl_locked && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl        <= '0;
      ctrl_locked <= 1'b0;
      lo_locked   <= 1'b0;
      hi_locked   <= 1'b0;
      cmp_lo      <= '0;
      cmp_hi      <= '1;
    end else begin
      if (wr_ctrl) begin
        ctrl.irq_en <= wdata[3];
        if (!ctrl_locked) begin
          ctrl.pin_en  <= wdata[2];
          ctrl.pin_pol <= wdata[1];
          ctrl.enable  <= wdata[0];
          ctrl_locked  <= 1'b1;
        end
      end
      if (wr_lo && !lo_locked) begin
        cmp_lo    <= wdata;
        lo_locked <= 1'b1;
      end
      if (wr_hi && !hi_locked) begin
        cmp_hi    <= wdata;
        hi_locked <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      case (ewm_reg_e'(addr))
        REG_CTRL:  rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl};
        REG_CMPLO: rdata = cmp_lo;
        REG_CMPHI: rdata = cmp_hi;
        default:   rdata = '0;
      endcase
    end
  end

  assert_err_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (sel && wr));
  assert_lo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_locked |=> $stable(cmp_lo));
  assert_hi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_locked |=> $stable(cmp_hi));
  assert_disabled_stays_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_locked && !ctrl.enable) |=> !ctrl.enable);

endmodule

// File: rtl/ewm_key_seq.sv
module ewm_key_seq
  import ewm_pkg::*;
#(
  parameter int              KEY_WINDOW = 15,
  parameter logic [REG_W-1:0] KEY_FIRST  = 8'hB4,
  parameter logic [REG_W-1:0] KEY_SECOND = 8'h2C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             serv_wr,
  input  logic [REG_W-1:0] serv_data,
  output logic             key_ok,
  output logic             key_bad
);

  localparam int EW = $clog2(KEY_WINDOW + 1);
  localparam logic [EW-1:0] LIMIT = EW'(KEY_WINDOW);

  logic          armed;
  logic [EW-1:0] elapsed;
  logic          timeout;

  assign timeout = armed && !serv_wr && (elapsed >= LIMIT);

  always_comb begin
    key_ok  = 1'b0;
    key_bad = 1'b0;
    if (active) begin
      if (!armed) begin
        key_bad = serv_wr && (serv_data != KEY_FIRST);
      end else if (serv_wr) begin
        if ((serv_data == KEY_SECOND) && (elapsed < LIMIT)) key_ok = 1'b1;
        else key_bad = 1'b1;
      end else begin
        key_bad = timeout;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      elapsed <= '0;
    end else if (!active) begin
      armed   <= 1'b0;
      elapsed <= '0;
    end else if (!armed) begin
      if (serv_wr && (serv_data == KEY_FIRST)) begin
        armed   <= 1'b1;
        elapsed <= '0;
      end
    end else if (serv_wr || timeout) begin
      armed   <= 1'b0;
      elapsed <= '0;
    end else begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assert_key_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_ok && key_bad));
  assert_elapsed_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (elapsed <= LIMIT));

endmodule

// File: rtl/ewm_pin_sync.sv
module ewm_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_q
);

  generate
    if (STAGES == 0) begin : g_direct
      assign pin_q = pin;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], pin} & {STAGES{1'b1}};
      end
      assign pin_q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ewm_core.sv
module ewm_core
  import ewm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             enable_rise,
  input  logic [REG_W-1:0] cmp_lo,
  input  logic [REG_W-1:0] cmp_hi,
  input  logic             key_ok,
  input  logic             key_bad,
  input  logic             ext_hit,
  output logic             fault
);

  logic [REG_W-1:0] cnt;
  logic expired, early, refresh_ok, refresh_early, trip;

  assign expired       = enable && win_expired(cnt, cmp_hi);
  assign early         = win_early(cnt, cmp_lo);
  assign refresh_ok    = enable && key_ok && !early && !expired;
  assign refresh_early = enable && key_ok && early;
  assign trip          = enable && (key_bad || refresh_early || expired || ext_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (enable_rise) cnt <= '0;
    else if (!enable)     cnt <= '0;
    else if (refresh_ok)  cnt <= '0;
    else                  cnt <= sat_inc(cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fault <= 1'b0;
    else if (enable_rise) fault <= 1'b0;
    else if (trip)        fault <= 1'b1;
  end

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  assert_refresh_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ok |=> (cnt == '0));
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !enable_rise && !refresh_ok && (cnt == {REG_W{1'b1}})) |=> (cnt == {REG_W{1'b1}}));
  assert_early_trips_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_early |=> fault);

endmodule

// File: rtl/ext_watchdog_mon.sv
module ext_watchdog_mon
  import ewm_pkg::*;
#(
  parameter int KEY_WINDOW  = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        bus_err,
  input  logic        mon_in,
  output logic        fault_out,
  output logic        irq_out
);

  ewm_ctrl_t        ctrl;
  logic [REG_W-1:0] cmp_lo, cmp_hi;
  logic             serv_wr, enable_rise;
  logic             key_ok, key_bad;
  logic             pin_q, ext_hit;

  ewm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .err(bus_err), .ctrl(ctrl),
    .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .serv_wr(serv_wr), .enable_rise(enable_rise)
  );

  ewm_key_seq #(.KEY_WINDOW(KEY_WINDOW)) u_key (
    .clk(clk), .rst_n(rst_n), .active(ctrl.enable), .serv_wr(serv_wr),
    .serv_data(bus_wdata), .key_ok(key_ok), .key_bad(key_bad)
  );

  ewm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(mon_in), .pin_q(pin_q)
  );

  assign ext_hit = ctrl.pin_en && pin_active(pin_q, ctrl.pin_pol);

  ewm_core u_core (
    .clk(clk), .rst_n(rst_n), .enable(ctrl.enable), .enable_rise(enable_rise),
    .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .key_ok(key_ok), .key_bad(key_bad),
    .ext_hit(ext_hit), .fault(fault_out)
  );

  assign irq_out = fault_out && ctrl.irq_en;

  assert_irq_follows_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> fault_out);

endmodule

// File: tb/tb_ext_watchdog_mon.sv
module tb_ext_watchdog_mon;

  localparam int W = 15;
  localparam int CLK_HALF = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_err;
  logic       mon_in = 1'b1;
  logic       fault_out, irq_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  ext_watchdog_mon dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .mon_in(mon_in), .fault_out(fault_out), .irq_out(irq_out)
  );

  always #CLK_HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_sel = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output logic e);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1 e = bus_err;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // expected fault after a refresh at edge r, counter base edge b
  function automatic int refresh_faults(int r, int b, int lo, int hi);
    if (r >= b + hi + 2) return 1;
    if ((r - b - 1) < lo) return 1;
    return 0;
  endfunction

  initial begin
    #(2 * CLK_HALF * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic e;
    logic [7:0] d;
    int base, f, r;
    void'($urandom(32'd2024));

    // R1 reset state, R4 service read
    do_reset();
    rd(2'd0, d); chk("R1 ctrl reset", d, 8'h00);
    rd(2'd2, d); chk("R1 lo reset", d, 8'h00);
    rd(2'd3, d); chk("R1 hi reset", d, 8'hFF);
    rd(2'd1, d); chk("R4 service reads zero", d, 8'h00);
    chk("R1 fault reset", fault_out, 0);
    chk("R1 irq reset", irq_out, 0);

    // R3 write-once compares, R4 service write no error
    wr(2'd2, 8'h05, e); chk("R3 lo first write err", e, 0);
    wr(2'd2, 8'h09, e); chk("R3 lo second write err", e, 1);
    rd(2'd2, d);        chk("R3 lo kept", d, 8'h05);
    wr(2'd3, 8'h40, e); chk("R3 hi first write err", e, 0);
    wr(2'd3, 8'h41, e); chk("R3 hi second write err", e, 1);
    rd(2'd3, d);        chk("R3 hi kept", d, 8'h40);
    wr(2'd1, 8'h55, e); chk("R4 service write err", e, 0);
    rd(2'd1, d);        chk("R4 service reads zero after write", d, 8'h00);

    // R2 control write-once
    do_reset();
    wr(2'd0, 8'h01, e); chk("R2 first ctrl write", e, 0);
    wr(2'd0, 8'h03, e); chk("R2 change locked bit err", e, 1);
    rd(2'd0, d);        chk("R2 locked bits kept", d, 8'h01);
    wr(2'd0, 8'h09, e); chk("R2 irq bit free write", e, 0);
    rd(2'd0, d);        chk("R2 irq bit stored", d, 8'h09);
    wr(2'd0, 8'hF1, e); chk("R2 reserved write no err", e, 0);
    rd(2'd0, d);        chk("R2 reserved read zero", d, 8'h01);

    // R5 expiry edge with hi=10
    do_reset();
    wr(2'd3, 8'd10, e);
    wr(2'd0, 8'h01, e);
    idle(11); chk("R5 no fault at E+hi+1", fault_out, 0);
    idle(1);  chk("R5 fault at E+hi+2", fault_out, 1);

    // R5 hi=0xFF never expires, across saturation
    do_reset();
    wr(2'd0, 8'h01, e);
    idle(300); chk("R5 0xFF never expires", fault_out, 0);

    // R6 refresh with gap k=W, then restart proven by second expiry
    do_reset();
    wr(2'd2, 8'd3, e); wr(2'd3, 8'd30, e);
    wr(2'd0, 8'h01, e); base = cyc;
    idle(5);
    wr(2'd1, 8'hB4, e); idle(W - 1);
    wr(2'd1, 8'h2C, e); r = cyc;
    chk("R6 gap W accepted", fault_out, refresh_faults(r, base, 3, 30));
    idle(31); chk("R6 counter restarted, no fault at +hi+1", fault_out, 0);
    idle(1);  chk("R6 restarted counter expires at +hi+2", fault_out, 1);

    // R7 late second byte
    do_reset();
    wr(2'd0, 8'h01, e);
    wr(2'd1, 8'hB4, e);
    idle(W); chk("R7 still waiting at F+W", fault_out, 0);
    idle(1); chk("R7 timeout at F+W+1", fault_out, 1);

    // R7 wrong second byte
    do_reset();
    wr(2'd0, 8'h01, e);
    wr(2'd1, 8'hB4, e);
    wr(2'd1, 8'h2D, e); chk("R7 wrong second byte", fault_out, 1);

    // R7 wrong first byte, R10 sticky, R11 irq
    do_reset();
    wr(2'd0, 8'h09, e);
    idle(2); chk("R7 before bad byte", fault_out, 0);
    wr(2'd1, 8'h2C, e); chk("R7 wrong first byte", fault_out, 1);
    chk("R11 irq with enable", irq_out, 1);
    wr(2'd1, 8'hB4, e); wr(2'd1, 8'h2C, e);
    idle(20); chk("R10 fault sticky", fault_out, 1);
    wr(2'd0, 8'h01, e); chk("R11 irq clear no err", e, 0);
    chk("R11 irq dropped", irq_out, 0);
    chk("R10 fault kept after irq clear", fault_out, 1);

    // R8 early refresh
    do_reset();
    wr(2'd2, 8'd20, e); wr(2'd3, 8'hFE, e);
    wr(2'd0, 8'h01, e);
    wr(2'd1, 8'hB4, e); wr(2'd1, 8'h2C, e);
    chk("R8 early refresh faults", fault_out, 1);
    // R8 boundary: counter equals lo
    do_reset();
    wr(2'd2, 8'd20, e); wr(2'd3, 8'hFE, e);
    wr(2'd0, 8'h01, e); base = cyc;
    idle(19);
    wr(2'd1, 8'hB4, e); wr(2'd1, 8'h2C, e); r = cyc;
    chk("R8 refresh at lo accepted", fault_out, refresh_faults(r, base, 20, 254));

    // R9 monitor pin, active low
    do_reset();
    mon_in = 1'b1;
    wr(2'd0, 8'h05, e);
    idle(5); chk("R9 inactive high level", fault_out, 0);
    mon_in = 1'b0;
    idle(2); chk("R9 not yet through sync", fault_out, 0);
    idle(1); chk("R9 active low trips", fault_out, 1);
    // active high
    do_reset();
    mon_in = 1'b0;
    wr(2'd0, 8'h07, e);
    idle(5); chk("R9 pol high idle", fault_out, 0);
    mon_in = 1'b1;
    idle(3); chk("R9 active high trips", fault_out, 1);
    // pin monitoring off
    do_reset();
    mon_in = 1'b0;
    wr(2'd0, 8'h01, e);
    idle(10); chk("R9 pin ignored when disabled", fault_out, 0);

    // R10 / R12 disabled block
    do_reset();
    mon_in = 1'b0;
    wr(2'd0, 8'h04, e);
    wr(2'd1, 8'h11, e); chk("R10 service write while disabled err", e, 0);
    idle(300); chk("R10 no fault while disabled", fault_out, 0);
    wr(2'd0, 8'h05, e); chk("R12 late enable refused", e, 1);
    rd(2'd0, d); chk("R12 enable stays clear", d, 8'h04);
    idle(5); chk("R12 still no fault", fault_out, 0);
    mon_in = 1'b1;

    // random windows and refresh timings (R5 R6 R8)
    for (int it = 0; it < 25; it++) begin
      int lo, hi, pred;
      lo = $urandom % 20;
      hi = lo + 5 + ($urandom % 40);
      do_reset();
      wr(2'd2, 8'(lo), e); wr(2'd3, 8'(hi), e);
      wr(2'd0, 8'h01, e); base = cyc;
      pred = 0;
      for (int j = 0; j < 6 && pred == 0; j++) begin
        int dly, k;
        dly = $urandom % (hi + 3);
        k = 1 + ($urandom % W);
        idle(dly);
        wr(2'd1, 8'hB4, e); f = cyc;
        if (k > 1) idle(k - 1);
        wr(2'd1, 8'h2C, e); r = cyc;
        if (f >= base + hi + 2) pred = 1;
        else pred = refresh_faults(r, base, lo, hi);
        if (pred == 0) base = r;
        chk("R6 R8 R5 random refresh", fault_out, pred);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule